// File: doc/BRIEF.md
# Mode-Steered Internal Data Memory

This block is the on-chip data store of a small 8-bit controller core. It holds a 128-byte general RAM, a second 128-byte RAM that can only be reached by indirect accesses, and a 128-entry register file that stands in for the special-function registers. One 8-bit address and a 2-bit access mode pick the target. In the lower half of the address space, direct and indirect accesses reach the same general RAM. In the upper half, the mode alone decides whether the register file or the indirect-only RAM is used.

A third mode treats the address as a bit number. It reaches a 16-byte window of the general RAM one bit at a time. A bit write is a read-modify-write of the byte that holds the bit. The same bytes can still be read and written as whole bytes. The core drives the address, mode, strobes and write data. Read data comes back in the same cycle, and writes land on the next rising clock edge.

Top module: `iram_space_decoder`

## Requirements
- R1: A synchronous active-high `rst` clears every byte of all three storages to zero, and a read in any later cycle returns 0 until that byte is written.
- R2: For addresses 00h–7Fh, direct mode (`mode`=00) and indirect mode (`mode`=01) reach the same general RAM byte. A write in one mode is read back in the other.
- R3: A direct access (`mode`=00) to an address in 80h–FFh reaches the register file.
- R4: An indirect access (`mode`=01) to an address in 80h–FFh reaches a separate indirect-only RAM. Writes to one of these two storages never change the other.
- R5: In bit mode (`mode`=10), a bit address n in 00h–7Fh refers to bit n mod 8 of general RAM byte 20h + n/8. `bit_rdata` returns that bit when `rd_en` is high, `rdata` returns the whole byte that holds it, and a write sets that bit to `wdata[0]`.
- R6: A bit write leaves the other seven bits of its byte unchanged. The 16 bytes at 20h–2Fh stay readable and writable as ordinary bytes.
- R7: A bit-mode access to an address in 80h–FFh, or any access with `mode`=11, raises `bit_err` while `rd_en` or `wr_en` is high. In that case `rdata` and `bit_rdata` read 0, and no storage changes.
- R8: Reads are combinational from the stored state and show the value held before any write in the same cycle. When `rd_en` is low, `rdata` and `bit_rdata` are 0. Writes take effect on the rising edge of `clk` when `wr_en` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 8 | Byte address, or bit number in bit mode |
| mode | input | 2 | 00 direct, 01 indirect, 10 bit, 11 reserved |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 8 | Write byte; bit 0 is the bit value in bit mode |
| rdata | output | 8 | Selected byte, 0 when not reading or on error |
| bit_rdata | output | 1 | Selected bit in bit mode |
| bit_err | output | 1 | Unsupported bit address or reserved mode |

## Verification
The write-then-read properties assume that the address and mode are stable while they are sampled at the clock edge. They also assume that a read-back is only meaningful when the cycle after a write carries no write of its own. The random stimulus changes its inputs only on the falling edge, so the first assumption always holds. Read-back properties are checked only where the random sequence happens to place a read right after a matching write, together with the directed back-to-back cases. The stimulus mixes all four modes and reaches every address, so reserved-mode and upper-half bit accesses occur often alongside legal ones.

// File: rtl/iram_space_decoder.sv
module iram_space_decoder #(
  parameter int AW = 8,
  parameter int DW = 8,
  parameter logic [AW-2:0] BIT_BASE = 'h20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr,
  input  logic [1:0]    mode,
  input  logic          rd_en,
  input  logic          wr_en,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata,
  output logic          bit_rdata,
  output logic          bit_err
);
  localparam int HALF = 1 << (AW - 1);
  localparam int BW   = $clog2(DW);

  logic [DW-1:0] lo_mem  [HALF];
  logic [DW-1:0] hi_mem  [HALF];
  logic [DW-1:0] sfr_mem [HALF];

  wire is_dir = (mode == 2'b00);
  wire is_bit = (mode == 2'b10);
  wire upper  = addr[AW-1];
  wire bad    = (is_bit && upper) || (mode == 2'b11);

  wire [AW-2:0] off      = addr[AW-2:0];
  wire [BW-1:0] bit_pos  = addr[BW-1:0];
  wire [AW-2:0] bit_byte = BIT_BASE + (AW-1)'(addr[AW-2:BW]);

  logic [DW-1:0] sel;
  always_comb begin
    if (is_bit)      sel = lo_mem[bit_byte];
    else if (!upper) sel = lo_mem[off];
    else if (is_dir) sel = sfr_mem[off];
    else             sel = hi_mem[off];
  end

  wire [DW-1:0] bmask  = DW'(1) << bit_pos;
  wire [DW-1:0] merged = (sel & ~bmask) | (wdata[0] ? bmask : '0);

  assign rdata     = (rd_en && !bad) ? sel : '0;
  assign bit_rdata = rd_en && is_bit && !bad && sel[bit_pos];
  assign bit_err   = bad && (rd_en || wr_en);

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < HALF; i++) begin
        lo_mem[i]  <= '0;
        hi_mem[i]  <= '0;
        sfr_mem[i] <= '0;
      end
    end else if (wr_en && !bad) begin
      if (is_bit)      lo_mem[bit_byte] <= merged;
      else if (!upper) lo_mem[off]      <= wdata;
      else if (is_dir) sfr_mem[off]     <= wdata;
      else             hi_mem[off]      <= wdata;
    end
  end
endmodule

// File: rtl/iram_space_chk.sv
module iram_space_chk (
  input logic       clk,
  input logic       rst,
  input logic [7:0] addr,
  input logic [1:0] mode,
  input logic       rd_en,
  input logic       wr_en,
  input logic [7:0] wdata,
  input logic [7:0] rdata,
  input logic       bit_rdata,
  input logic       bit_err
);
  // R1
  reset_clears_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (rdata == 8'h00 && !bit_rdata));

  // R3
  direct_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr_en && mode == 2'b00) ##1
    (rd_en && !wr_en && mode == 2'b00 && addr == $past(addr))
    |-> rdata == $past(wdata));

  // R4
  indirect_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr_en && mode == 2'b01) ##1
    (rd_en && !wr_en && mode == 2'b01 && addr == $past(addr))
    |-> rdata == $past(wdata));

  // R5
  bit_readback_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr_en && mode == 2'b10 && !addr[7]) ##1
    (rd_en && !wr_en && mode == 2'b10 && addr == $past(addr))
    |-> bit_rdata == $past(wdata[0]));

  // R6
  bit_neighbours_chk: assert property (@(posedge clk) disable iff (rst)
    (!rst && wr_en && rd_en && mode == 2'b10 && !addr[7]) ##1
    (rd_en && !wr_en && mode == 2'b10 && addr == $past(addr))
    |-> ((rdata ^ $past(rdata)) & ~(8'h01 << addr[2:0])) == 8'h00);

  // R7
  error_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    bit_err |-> (rdata == 8'h00 && !bit_rdata));
endmodule

bind iram_space_decoder iram_space_chk u_chk (.*);

// File: tb/sim_iram_space_decoder.sv
`timescale 1ns/100ps
module sim_iram_space_decoder;
  logic clk = 0, rst = 1, rd_en = 0, wr_en = 0, bit_rdata, bit_err;
  logic [7:0] addr = 0, wdata = 0, rdata;
  logic [1:0] mode = 0;
  int checks = 0, errors = 0;
  logic [7:0] m_lo [128], m_hi [128], m_sf [128];

  always #2.5 clk = ~clk;

  iram_space_decoder u0 (.clk(clk), .rst(rst), .addr(addr), .mode(mode),
    .rd_en(rd_en), .wr_en(wr_en), .wdata(wdata), .rdata(rdata),
    .bit_rdata(bit_rdata), .bit_err(bit_err));

  function automatic logic is_bad(input logic [7:0] a, input logic [1:0] m);
    return (m == 2'b11) || (m == 2'b10 && a[7]);
  endfunction

  function automatic logic [7:0] ref_byte(input logic [7:0] a, input logic [1:0] m);
    if (m == 2'b10) return m_lo[7'h20 + {3'b0, a[6:3]}];
    if (!a[7]) return m_lo[a[6:0]];
    if (m == 2'b00) return m_sf[a[6:0]];
    return m_hi[a[6:0]];
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 128; i++) begin m_lo[i] = 0; m_hi[i] = 0; m_sf[i] = 0; end
  endtask

  task automatic model_write(input logic [7:0] a, input logic [1:0] m, input logic [7:0] d);
    logic [7:0] b;
    if (is_bad(a, m)) return;
    if (m == 2'b10) begin
      b = m_lo[7'h20 + {3'b0, a[6:3]}];
      b[a[2:0]] = d[0];
      m_lo[7'h20 + {3'b0, a[6:3]}] = b;
    end else if (!a[7]) m_lo[a[6:0]] = d;
    else if (m == 2'b00) m_sf[a[6:0]] = d;
    else m_hi[a[6:0]] = d;
  endtask

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic op(input string tag, input logic [7:0] a, input logic [1:0] m,
                    input logic r, input logic w, input logic [7:0] d);
    logic [7:0] eb;
    logic bad;
    @(negedge clk);
    addr = a; mode = m; rd_en = r; wr_en = w; wdata = d;
    #1;
    bad = is_bad(a, m);
    eb = (r && !bad) ? ref_byte(a, m) : 8'h00;
    check(tag, rdata, eb);
    check(tag, {7'b0, bit_rdata}, {7'b0, (r && m == 2'b10 && !bad) ? eb[a[2:0]] : 1'b0});
    check(tag, {7'b0, bit_err}, {7'b0, bad && (r || w)});
    if (w) model_write(a, m, d);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; rd_en = 0; wr_en = 0;
    @(negedge clk);
    rst = 0;
    model_reset();
  endtask

  initial begin
    #(200000 * 5);
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    model_reset();
    do_reset();
    // R1: reset state
    op("R1", 8'h05, 2'b00, 1, 0, 0);
    op("R1", 8'h85, 2'b00, 1, 0, 0);
    op("R1", 8'hA0, 2'b01, 1, 0, 0);
    // R3 / R4: same address, two storages
    op("R3", 8'h85, 2'b00, 0, 1, 8'hA5);
    op("R4", 8'h85, 2'b01, 1, 0, 0);
    op("R3", 8'h85, 2'b00, 1, 0, 0);
    op("R4", 8'hF0, 2'b01, 0, 1, 8'h3C);
    op("R3", 8'hF0, 2'b00, 1, 0, 0);
    op("R4", 8'hF0, 2'b01, 1, 0, 0);
    // R2: lower half shared
    op("R2", 8'h10, 2'b01, 0, 1, 8'h77);
    op("R2", 8'h10, 2'b00, 1, 0, 0);
    // R5: bit 0x0B -> byte 21h bit 3
    op("R5", 8'h0B, 2'b10, 0, 1, 8'h01);
    op("R5", 8'h21, 2'b00, 1, 0, 0);
    op("R5", 8'h0B, 2'b10, 1, 0, 0);
    op("R5", 8'h7F, 2'b10, 0, 1, 8'h01);
    op("R5", 8'h2F, 2'b01, 1, 0, 0);
    // R6: clear bit 0x14 -> byte 22h bit 4, neighbours kept
    op("R6", 8'h22, 2'b00, 0, 1, 8'hF0);
    op("R6", 8'h14, 2'b10, 1, 1, 8'h00);
    op("R6", 8'h22, 2'b00, 1, 0, 0);
    op("R6", 8'h14, 2'b10, 1, 0, 0);
    // R7: unsupported bit address and reserved mode change nothing
    op("R7", 8'h90, 2'b10, 1, 1, 8'h00);
    op("R7", 8'h22, 2'b00, 1, 0, 0);
    op("R7", 8'h85, 2'b11, 1, 1, 8'h00);
    op("R7", 8'h85, 2'b00, 1, 0, 0);
    op("R7", 8'h90, 2'b00, 1, 0, 0);
    // R8: read strobe low, and read shows pre-write value
    op("R8", 8'h10, 2'b00, 0, 0, 0);
    op("R8", 8'h10, 2'b00, 1, 1, 8'h12);
    op("R8", 8'h10, 2'b00, 1, 0, 0);
    // random mix
    for (int i = 0; i < 4000; i++) begin
      logic [7:0] a, d;
      logic [1:0] m;
      string tg;
      a = 8'($urandom);
      m = 2'($urandom);
      d = 8'($urandom);
      if (($urandom % 3) == 0) a = {a[7], 3'b010, a[3:0]};
      if (is_bad(a, m)) tg = "R7";
      else if (m == 2'b10) tg = "R5";
      else if (!a[7]) tg = "R2";
      else if (m == 2'b00) tg = "R3";
      else tg = "R4";
      op(tg, a, m, 1'($urandom), 1'($urandom), d);
    end
    // R1: reset in mid-run clears everything
    do_reset();
    for (int i = 0; i < 256; i += 17) begin
      op("R1", 8'(i), 2'b00, 1, 0, 0);
      op("R1", 8'(i), 2'b01, 1, 0, 0);
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule